// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block turns the peripheral clock into the timing skeleton of an I2C master's SCL line. A prescaler divides the peripheral clock by a programmable factor to form an internal time base, which must stay below 20 MHz. The block emits this time base as a one-cycle strobe. A second stage counts internal-clock strobes to lay out one SCL period. The period is a fixed 20 counts, plus eight counts per step of a coarse divider field, plus a separately supplied compensation count. The compensation count covers SCL rise time, fall time and internal delay.

Both divider fields arrive in one packed configuration word. The compensation count has its own input. The configuration is captured at the start of every SCL period. The period is split into a low phase and a high phase. The high phase advances only while the SCL line is seen high, so a target that holds SCL low lengthens the period. The master bit engine uses the phase-start strobes and the internal-clock strobe. Choosing the field values for a target bit rate is left to software.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted, and after reset with `run` low, `scl_low_o`, `ick_tick`, `lo_tick` and `hi_tick` are all 0.
- R2: While running, `ick_tick` pulses for one cycle every D = PS+1 peripheral-clock cycles, where PS is the prescale field. The first pulse of a phase comes in its D-th cycle. A low phase of L counts therefore holds exactly L pulses.
- R3: `clk_cfg` packs the prescale field PS in bits [PRE_W-1:0] and the 6-bit coarse divider G in the bits directly above it, [PRE_W+5:PRE_W].
- R4: One SCL period is P = 20 + 8*G + C internal-clock counts, where C is `edge_comp`. The low phase lasts ceil(P/2) counts and the high phase lasts floor(P/2) counts. With SCL unstretched, these are L*D and H*D peripheral-clock cycles.
- R5: `scl_low_o` is 1 for exactly the low phase. `lo_tick` is high only in the first cycle of each low phase, and `hi_tick` only in the first cycle of each high phase. The two strobes never coincide.
- R6: During the high phase, the prescaler and the phase counter advance only on cycles when `scl_in` is sampled 1. Holding `scl_in` low for k cycles at the start of the high phase lengthens that phase by exactly k cycles.
- R7: Driving `run` to 0 releases SCL and stops all strobes from the next cycle. A 0-to-1 transition of `run` starts a fresh low phase in the following cycle, with `lo_tick` set and the full low length.
- R8: PS, G and C are sampled only when a low phase starts. A change in the middle of a period first takes effect at the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enable; a rising level restarts the period |
| clk_cfg | input | PRE_W+GD_W | Packed prescale (low bits) and coarse divider (above) |
| edge_comp | input | RC_W | Rise/fall/internal-delay compensation count |
| scl_in | input | 1 | Sampled SCL line level (already synchronised) |
| ick_tick | output | 1 | One-cycle internal-clock strobe |
| scl_low_o | output | 1 | 1 while SCL is to be driven low |
| lo_tick | output | 1 | First cycle of a low phase |
| hi_tick | output | 1 | First cycle of a high phase |

## Verification
Several settings are tried: the smallest setting (D=1, P=20), odd and even periods, and the largest prescale (D=8). They are combined with the maximum coarse divider and compensation. The odd periods show that the extra count goes to the low phase, and the large prescale shows that the top field bit is decoded. Measured low, high and strobe counts separate faults in the prescaler from faults in the period arithmetic. A stretched high phase checks that counting freezes while SCL is held low. A mid-period stop and restart, and a mid-period configuration change, check that state is discarded on restart and that new settings are not applied early.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int PRE_W = 3,
  parameter int GD_W  = 6,
  parameter int RC_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [PRE_W+GD_W-1:0] clk_cfg,
  input  logic [RC_W-1:0]       edge_comp,
  input  logic                  scl_in,
  output logic                  ick_tick,
  output logic                  scl_low_o,
  output logic                  lo_tick,
  output logic                  hi_tick
);
  localparam int CFG_W = PRE_W + GD_W;
  localparam int MAXP  = 20 + 8 * ((1 << GD_W) - 1) + (1 << RC_W) - 1;
  localparam int CNT_W = $clog2(MAXP + 2);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t              st;
  logic [PRE_W-1:0] pre_cnt, cdf_q;
  logic [CNT_W-1:0] ph_cnt, lo_len, hi_len;

  wire [CNT_W-1:0] per  = CNT_W'(20) + (CNT_W'(clk_cfg[CFG_W-1:PRE_W]) << 3) + CNT_W'(edge_comp);
  wire [CNT_W-1:0] lo_n = (per + CNT_W'(1)) >> 1;
  wire [CNT_W-1:0] hi_n = per >> 1;

  wire adv      = (st == S_LOW) || (st == S_HIGH && scl_in);
  wire step     = adv && (pre_cnt == cdf_q);
  wire end_low  = (st == S_LOW)  && step && (ph_cnt == lo_len - CNT_W'(1));
  wire end_high = (st == S_HIGH) && step && (ph_cnt == hi_len - CNT_W'(1));

  assign ick_tick  = step;
  assign scl_low_o = (st == S_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pre_cnt <= '0;
      ph_cnt  <= '0;
      cdf_q   <= '0;
      lo_len  <= '0;
      hi_len  <= '0;
      lo_tick <= 1'b0;
      hi_tick <= 1'b0;
    end else begin
      lo_tick <= 1'b0;
      hi_tick <= 1'b0;
      if (!run) begin
        st      <= S_IDLE;
        pre_cnt <= '0;
        ph_cnt  <= '0;
      end else if (st == S_IDLE || end_high) begin
        st      <= S_LOW;
        pre_cnt <= '0;
        ph_cnt  <= '0;
        cdf_q   <= clk_cfg[PRE_W-1:0];
        lo_len  <= lo_n;
        hi_len  <= hi_n;
        lo_tick <= 1'b1;
      end else if (end_low) begin
        st      <= S_HIGH;
        pre_cnt <= '0;
        ph_cnt  <= '0;
        hi_tick <= 1'b1;
      end else if (step) begin
        pre_cnt <= '0;
        ph_cnt  <= ph_cnt + CNT_W'(1);
      end else if (adv) begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_low_o && !ick_tick && !lo_tick && !hi_tick)); // R7
  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (lo_tick && scl_low_o)); // R7
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (pre_cnt <= cdf_q)); // R2
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW) |-> (ph_cnt < lo_len)); // R4
  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH) |-> (ph_cnt < hi_len)); // R4
  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st == S_HIGH && !scl_in) |=> ($stable(ph_cnt) && $stable(pre_cnt))); // R6
  AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_tick && hi_tick)); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH) |-> ($stable(lo_len) && $stable(hi_len) && $stable(cdf_q))); // R8
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  localparam int PRE_W = 3, GD_W = 6, RC_W = 6;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, hold = 1'b0;
  logic [PRE_W+GD_W-1:0] clk_cfg = '0;
  logic [RC_W-1:0] edge_comp = '0;
  logic scl_in, ick_tick, scl_low_o, lo_tick, hi_tick;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign scl_in = !scl_low_o && !hold;

  scl_rate_gen #(.PRE_W(PRE_W), .GD_W(GD_W), .RC_W(RC_W)) i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_cfg(clk_cfg), .edge_comp(edge_comp),
    .scl_in(scl_in), .ick_tick(ick_tick), .scl_low_o(scl_low_o),
    .lo_tick(lo_tick), .hi_tick(hi_tick));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cnt_low(output int n, output int t, output int first);
    n = 0; t = 0; first = 0;
    while (scl_low_o && n < 5000) begin
      n++;
      if (ick_tick) begin
        t++;
        if (first == 0) first = n;
      end
      @(negedge clk);
    end
  endtask

  task automatic cnt_high(input int k, output int n);
    n = 0;
    while (!lo_tick && n < 5000) begin
      n++;
      if (k > 0 && n == k + 1) hold = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic start_run(input int cdf, input int gd, input int rc);
    @(negedge clk);
    run = 1'b0;
    clk_cfg = {GD_W'(gd), PRE_W'(cdf)};
    edge_comp = RC_W'(rc);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk(lo_tick && scl_low_o, "R7 start strobe", int'(lo_tick), 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!scl_low_o && !ick_tick && !lo_tick && !hi_tick, "R1 in reset", int'(scl_low_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_low_o && !ick_tick && !lo_tick && !hi_tick, "R1 idle after reset", int'(ick_tick), 0);
  endtask

  task automatic t_period(input int cdf, input int gd, input int rc, input int k);
    int p, l, h, d, nl, nt, nf, nh;
    p = 20 + 8 * gd + rc; l = (p + 1) / 2; h = p / 2; d = cdf + 1;
    start_run(cdf, gd, rc);
    hold = (k > 0);
    cnt_low(nl, nt, nf);
    chk(nl == l * d, "R4/R3 low length", nl, l * d);
    chk(nt == l, "R2 strobes in low", nt, l);
    chk(nf == d, "R2 first strobe cycle", nf, d);
    chk(hi_tick, "R5 high strobe", int'(hi_tick), 1);
    cnt_high(k, nh);
    hold = 1'b0;
    chk(nh == h * d + k, k > 0 ? "R6 stretched high" : "R4 high length", nh, h * d + k);
    chk(lo_tick && scl_low_o, "R5 next low strobe", int'(lo_tick), 1);
  endtask

  task automatic t_restart;
    int nl, nt, nf;
    start_run(1, 0, 0);
    repeat (25) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(!scl_low_o && !ick_tick && !lo_tick && !hi_tick, "R7 stop releases", int'(scl_low_o), 0);
    repeat (4) begin
      @(negedge clk);
      chk(!ick_tick && !scl_low_o, "R7 quiet while stopped", int'(ick_tick), 0);
    end
    run = 1'b1;
    @(negedge clk);
    chk(lo_tick && scl_low_o, "R7 restart strobe", int'(lo_tick), 1);
    cnt_low(nl, nt, nf);
    chk(nl == 20, "R7 full low after restart", nl, 20);
  endtask

  task automatic t_cfg_change;
    int nl, nt, nf, nh;
    start_run(0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    clk_cfg = {GD_W'(2), PRE_W'(0)};
    cnt_low(nl, nt, nf);
    chk(nl == 8, "R8 current low kept", nl + 2, 10);
    cnt_high(0, nh);
    chk(nh == 10, "R8 current high kept", nh, 10);
    cnt_low(nl, nt, nf);
    chk(nl == 18, "R8 new low applied", nl, 18);
    cnt_high(0, nh);
    chk(nh == 18, "R8 new high applied", nh, 18);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_period(0, 0, 0, 0);
    t_period(3, 1, 5, 0);
    t_period(7, 2, 1, 0);
    t_period(4, 0, 3, 0);
    t_period(1, 63, 63, 0);
    t_period(2, 1, 0, 7);
    t_restart();
    t_cfg_change();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule